// File: doc/BRIEF.md
# Cascadable LCD Column Driver Loader

This block is the digital core of a dot-matrix LCD column driver meant to sit in a chain of identical devices. Display data arrives four bits at a time. A nibble is taken on every falling edge of a shift strobe, and twenty strobes fill an 80-column line register. Once its line is full, the device pulls its chain enable output low. The next device in the chain then starts accepting the same data stream, so the controller never has to drive an enable line. The first device of a chain has its enable input tied low.

On the falling edge of a latch strobe, the whole line is copied into an output register, the nibble counter restarts and the enable output is released. Each column output is a 2-bit drive-level code. It is formed from the latched bit and an AC frame input, which flips the polarity of the levels without touching the data path.

A single direction input does two things. It sets whether nibbles fill the line from the top column down or from column 0 up. It also sets which of the two enable pins is the input and which is the output. All strobes are sampled on the system clock `clk_i` and acted on at their detected falling edge.

Top module: `lcdcol_driver`

## Requirements
- R1: On each detected falling edge of `scl_i` (sampled 1, then 0), the block captures `data_i` as one nibble, provided the selected enable input is low and fewer than 20 nibbles have been captured since the last latch. Twenty nibbles fill all 80 columns.
- R2: With `dir_i` = 0, nibble k (k = 0 for the first nibble after a latch) writes data_i[3], [2], [1], [0] to columns 79-4k, 78-4k, 77-4k, 76-4k.
- R3: With `dir_i` = 1, nibble k writes data_i[3], [2], [1], [0] to columns 4k, 4k+1, 4k+2, 4k+3.
- R4: With `dir_i` = 0, pin 1 is the output (`en1_oe_o` = 1, `en2_oe_o` = 0) and `en2_i` is the enable input. With `dir_i` = 1 the roles swap and `en1_i` is the enable input. Exactly one output enable is high at any time.
- R5: The driven enable output (`en1_o` and `en2_o`, which carry the same value) goes low in the cycle after the 20th nibble is captured. It stays low until a detected latch falling edge, after which it is high again.
- R6: Shift edges that arrive while the selected enable input is high, or after 20 nibbles have been taken, change neither the line contents nor the nibble count.
- R7: On a detected falling edge of `lp_i`, all columns of the output register load the line register together, and the nibble count returns to 0. Columns not rewritten since the previous latch keep their earlier contents. Between latch edges the output register holds its value.
- R8: Column j appears on seg_o[2j+1:2j]. The level codes are V0 = 2'b00, V2 = 2'b01, V3 = 2'b10 and V5 = 2'b11. A latched 1 gives V0 when `fr_i` is 1 and V5 when `fr_i` is 0. A latched 0 gives V2 when `fr_i` is 1 and V3 when `fr_i` is 0. The frame input acts combinationally.
- R9: While `rst_ni` is low, the line register, the output register and the nibble count are cleared, and the enable output is high.
- R10: If shift and latch falling edges are detected in the same cycle, the latch takes effect and the nibble is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Data shift strobe, acted on at its falling edge |
| lp_i | input | 1 | Line latch strobe, acted on at its falling edge |
| fr_i | input | 1 | AC frame polarity |
| dir_i | input | 1 | Direction select: fill order and enable pin roles |
| data_i | input | 4 | Display data nibble |
| en1_i | input | 1 | Enable pin 1, input value (active low) |
| en2_i | input | 1 | Enable pin 2, input value (active low) |
| en1_o | output | 1 | Enable pin 1, driven value |
| en1_oe_o | output | 1 | Enable pin 1 output enable |
| en2_o | output | 1 | Enable pin 2, driven value |
| en2_oe_o | output | 1 | Enable pin 2 output enable |
| seg_o | output | 160 | Per-column 2-bit drive-level codes |

## Verification
The bench first sends 21 nibbles. A counter missing its limit guard would keep counting past the full line and release the enable output. The bench also latches a partly rewritten line: a design that clears the line register on latch, or that shifts the data instead of addressing it, would move or lose the columns that were not rewritten. Simultaneous shift and latch edges come next; a design that gives the shift priority would count one nibble too many and pull the enable low a nibble early. The bench also applies shifts while the enable input is high and swaps the direction, which exposes a mirrored column map or enable roles that are not swapped.

// File: rtl/lcdcol_pkg.sv
package lcdcol_pkg;
  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V3 = 2'b10,
    LVL_V5 = 2'b11
  } level_e;

  function automatic level_e pick_level(input logic on, input logic fr);
    if (on) return fr ? LVL_V0 : LVL_V5;
    else    return fr ? LVL_V2 : LVL_V3;
  endfunction
endpackage

// File: rtl/lcdcol_edge_fall.sv
module lcdcol_edge_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/lcdcol_capture.sv
module lcdcol_capture #(
  parameter int SEG_N = 80,
  parameter int BUS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             latch_i,
  input  logic             en_n_i,
  input  logic             dir_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [SEG_N-1:0] line_o,
  output logic             full_o
);
  localparam int STEPS = SEG_N / BUS_W;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take;
  logic [BUS_W-1:0] data_rev;

  // latch wins over a coincident shift
  assign take   = shift_i & ~latch_i & ~en_n_i & (cnt_q < CNT_W'(STEPS));
  assign full_o = (cnt_q == CNT_W'(STEPS));

  always_comb begin
    for (int b = 0; b < BUS_W; b++) data_rev[b] = data_i[BUS_W-1-b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (latch_i) cnt_q <= '0;
    else if (take)    cnt_q <= cnt_q + 1'b1;
  end

  // each column group is addressed by the slot that fills it
  for (genvar g = 0; g < STEPS; g++) begin : g_grp
    logic [BUS_W-1:0] grp_q;
    logic [CNT_W-1:0] slot;
    logic             wr;

    assign slot = dir_i ? CNT_W'(g) : CNT_W'(STEPS - 1 - g);
    assign wr   = take & (cnt_q == slot);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  grp_q <= '0;
      else if (wr)  grp_q <= dir_i ? data_rev : data_i;
    end

    assign line_o[g*BUS_W +: BUS_W] = grp_q;
  end
endmodule

// File: rtl/lcdcol_latch.sv
module lcdcol_latch #(
  parameter int SEG_N = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEG_N-1:0] line_i,
  output logic [SEG_N-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bits_o <= '0;
    else if (load_i) bits_o <= line_i;
  end
endmodule

// File: rtl/lcdcol_level.sv
module lcdcol_level #(
  parameter int SEG_N = 80
) (
  input  logic [SEG_N-1:0]   bits_i,
  input  logic               fr_i,
  output logic [2*SEG_N-1:0] seg_o
);
  import lcdcol_pkg::*;

  for (genvar j = 0; j < SEG_N; j++) begin : g_col
    assign seg_o[2*j +: 2] = pick_level(bits_i[j], fr_i);
  end
endmodule

// File: rtl/lcdcol_driver.sv
module lcdcol_driver #(
  parameter int SEG_N = 80,
  parameter int BUS_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               lp_i,
  input  logic               fr_i,
  input  logic               dir_i,
  input  logic [BUS_W-1:0]   data_i,
  input  logic               en1_i,
  input  logic               en2_i,
  output logic               en1_o,
  output logic               en1_oe_o,
  output logic               en2_o,
  output logic               en2_oe_o,
  output logic [2*SEG_N-1:0] seg_o
);
  logic             scl_fall;
  logic             lp_fall;
  logic             en_in_n;
  logic             full;
  logic [SEG_N-1:0] line;
  logic [SEG_N-1:0] out_bits;

  lcdcol_edge_fall u_scl_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(scl_i), .fall_o(scl_fall)
  );

  lcdcol_edge_fall u_lp_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(lp_i), .fall_o(lp_fall)
  );

  // dir low: pin 2 listens, pin 1 drives
  assign en_in_n  = dir_i ? en1_i : en2_i;
  assign en1_oe_o = ~dir_i;
  assign en2_oe_o = dir_i;
  assign en1_o    = ~full;
  assign en2_o    = ~full;

  lcdcol_capture #(.SEG_N(SEG_N), .BUS_W(BUS_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(scl_fall),
    .latch_i(lp_fall),
    .en_n_i (en_in_n),
    .dir_i  (dir_i),
    .data_i (data_i),
    .line_o (line),
    .full_o (full)
  );

  lcdcol_latch #(.SEG_N(SEG_N)) u_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(lp_fall),
    .line_i(line),
    .bits_o(out_bits)
  );

  lcdcol_level #(.SEG_N(SEG_N)) u_lvl (
    .bits_i(out_bits),
    .fr_i  (fr_i),
    .seg_o (seg_o)
  );
endmodule

// File: rtl/lcdcol_driver_chk.sv
module lcdcol_driver_chk #(
  parameter int SEG_N = 80
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dir_i,
  input logic               fr_i,
  input logic               scl_fall_i,
  input logic               lp_fall_i,
  input logic               en1_o,
  input logic               en1_oe_o,
  input logic               en2_oe_o,
  input logic [SEG_N-1:0]   out_bits_i,
  input logic [2*SEG_N-1:0] seg_o
);
  logic [SEG_N-1:0] seg_hi;

  always_comb begin
    for (int j = 0; j < SEG_N; j++) seg_hi[j] = seg_o[2*j+1];
  end

  // R5
  en_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_fall_i |=> en1_o);

  // R5
  en_engage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en1_o) |-> $past(scl_fall_i));

  // R4
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({en1_oe_o, en2_oe_o}) && (dir_i == en2_oe_o));

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_fall_i |=> $stable(out_bits_i));

  // R8
  lvl_fr_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_i |-> (seg_hi == '0));

  // R8
  lvl_fr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fr_i |-> (seg_hi == '1));
endmodule

bind lcdcol_driver lcdcol_driver_chk #(.SEG_N(SEG_N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dir_i     (dir_i),
  .fr_i      (fr_i),
  .scl_fall_i(scl_fall),
  .lp_fall_i (lp_fall),
  .en1_o     (en1_o),
  .en1_oe_o  (en1_oe_o),
  .en2_oe_o  (en2_oe_o),
  .out_bits_i(out_bits),
  .seg_o     (seg_o)
);

// File: tb/lcdcol_driver_tb_top.sv
`timescale 1ns/1ps
module lcdcol_driver_tb_top;
  localparam int N = 80;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b0, lp = 1'b0, fr = 1'b0, dir = 1'b0;
  logic [3:0]   data = '0;
  logic         en1 = 1'b0, en2 = 1'b0;
  logic         en1_o, en1_oe, en2_o, en2_oe;
  logic [2*N-1:0] seg;

  int checks_n = 0;
  int fails_n  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  lcdcol_driver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .lp_i(lp), .fr_i(fr),
    .dir_i(dir), .data_i(data), .en1_i(en1), .en2_i(en2),
    .en1_o(en1_o), .en1_oe_o(en1_oe), .en2_o(en2_o), .en2_oe_o(en2_oe),
    .seg_o(seg)
  );

  // behavioural reference: addressed columns, integer count
  bit [N-1:0] m_line, m_out;
  int m_cnt;
  bit m_sp, m_lp, m_sf, m_lf, m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = '0; m_out = '0; m_cnt = 0; m_sp = 0; m_lp = 0;
    end else begin
      m_sf = m_sp && !scl;
      m_lf = m_lp && !lp;
      m_en = dir ? en1 : en2;
      if (m_lf) begin
        m_out = m_line;
        m_cnt = 0;
      end else if (m_sf && !m_en && m_cnt < 20) begin
        for (int b = 0; b < 4; b++) begin
          int idx;
          idx = dir ? 4*m_cnt + (3-b) : 79 - 4*m_cnt - (3-b);
          m_line[idx] = data[b];
        end
        m_cnt++;
      end
      m_sp = scl;
      m_lp = lp;
    end
  end

  function automatic logic [1:0] exp_code(bit on, bit f);
    if (on) return f ? 2'b00 : 2'b11;
    return f ? 2'b01 : 2'b10;
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2*N-1:0] es;
      logic een;
      for (int j = 0; j < N; j++) es[2*j +: 2] = exp_code(m_out[j], fr);
      een = (m_cnt == 20) ? 1'b0 : 1'b1;
      checks_n++;
      if (seg !== es) begin
        fails_n++;
        $display("FAIL R7/R8 cycle seg: got %h exp %h", seg, es);
      end
      checks_n++;
      if (en1_o !== een || en2_o !== een) begin
        fails_n++;
        $display("FAIL R5 cycle enable: got %b%b exp %b", en1_o, en2_o, een);
      end
      checks_n++;
      if (en1_oe !== !dir || en2_oe !== dir) begin
        fails_n++;
        $display("FAIL R4 cycle oe: got %b%b exp %b%b", en1_oe, en2_oe, !dir, dir);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic nib(logic [3:0] d);
    data = d; scl = 1'b1; tick(2);
    scl = 1'b0; tick(2);
  endtask

  task automatic latch();
    lp = 1'b1; tick(2);
    lp = 1'b0; tick(2);
  endtask

  task automatic chk_seg(int j, logic [1:0] e, string tag);
    checks_n++;
    if (seg[2*j +: 2] !== e) begin
      fails_n++;
      $display("FAIL %s seg%0d: got %b exp %b", tag, j, seg[2*j +: 2], e);
    end
  endtask

  task automatic chk_bit(logic a, logic e, string tag);
    checks_n++;
    if (a !== e) begin
      fails_n++;
      $display("FAIL %s: got %b exp %b", tag, a, e);
    end
  endtask

  function automatic logic [3:0] pat(int k);
    if (k == 0)  return 4'h9;
    if (k == 19) return 4'h6;
    return 4'(k);
  endfunction

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9 reset state, fr low -> off = V3
    chk_seg(0, 2'b10, "R9");
    chk_seg(79, 2'b10, "R9");
    chk_bit(en1_o, 1'b1, "R9 en1_o");
    // R4 dir low roles
    chk_bit(en1_oe, 1'b1, "R4 en1_oe");
    chk_bit(en2_oe, 1'b0, "R4 en2_oe");

    // R6 enable input high blocks capture
    en2 = 1'b1;
    repeat (3) nib(4'hF);
    en2 = 1'b0;
    latch();
    chk_seg(79, 2'b10, "R6");
    chk_seg(76, 2'b10, "R6");
    chk_bit(en1_o, 1'b1, "R6 en1_o");

    // R1 R2 full line, dir low
    fr = 1'b1;
    for (int k = 0; k < 19; k++) nib(pat(k));
    chk_bit(en1_o, 1'b1, "R5 before 20th");
    nib(pat(19));
    chk_bit(en1_o, 1'b0, "R5 after 20th");
    nib(4'hF);  // R6 21st nibble ignored
    chk_bit(en1_o, 1'b0, "R6 after 21st");
    chk_seg(79, 2'b01, "R7 before latch");
    latch();
    chk_bit(en1_o, 1'b1, "R5 after latch");
    chk_seg(79, 2'b00, "R2");
    chk_seg(78, 2'b01, "R2");
    chk_seg(76, 2'b00, "R2");
    chk_seg(3, 2'b01, "R2");
    chk_seg(2, 2'b00, "R2");
    chk_seg(1, 2'b00, "R1");
    chk_seg(0, 2'b01, "R1");

    // R8 frame polarity
    fr = 1'b0;
    tick(1);
    chk_seg(79, 2'b11, "R8");
    chk_seg(78, 2'b10, "R8");
    fr = 1'b1;

    // R3 R4 dir high
    dir = 1'b1; en1 = 1'b0; en2 = 1'b1;
    tick(1);
    chk_bit(en2_oe, 1'b1, "R4 en2_oe");
    chk_bit(en1_oe, 1'b0, "R4 en1_oe");
    for (int k = 0; k < 20; k++) nib(pat(k));
    chk_bit(en2_o, 1'b0, "R5 en2_o");
    latch();
    chk_seg(0, 2'b00, "R3");
    chk_seg(1, 2'b01, "R3");
    chk_seg(3, 2'b00, "R3");
    chk_seg(79, 2'b01, "R3");
    chk_seg(78, 2'b00, "R3");

    // R7 partial line keeps older columns
    dir = 1'b0; en2 = 1'b0;
    nib(4'hF); nib(4'hF);
    latch();
    chk_seg(79, 2'b00, "R7");
    chk_seg(72, 2'b00, "R7");
    chk_seg(0, 2'b00, "R7");
    chk_seg(1, 2'b01, "R7");

    // R10 coincident edges: nibble dropped
    data = 4'hF; scl = 1'b1; lp = 1'b1; tick(2);
    scl = 1'b0; lp = 1'b0; tick(2);
    for (int k = 0; k < 19; k++) nib(4'h0);
    chk_bit(en1_o, 1'b1, "R10 after 19");
    nib(4'h0);
    chk_bit(en1_o, 1'b0, "R10 after 20");
    latch();

    // R9 reset mid-line
    repeat (5) nib(4'hF);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(1);
    chk_seg(0, 2'b01, "R9 mid");
    chk_seg(79, 2'b01, "R9 mid");
    chk_bit(en1_o, 1'b1, "R9 mid en1_o");

    tick(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks_n++;
      fails_n++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
      $finish;
    end
  end
endmodule